// File: doc/BRIEF.md
# Power-Up Self-Test Indicator Sequencer

This block runs a short bus-level self-test when reset is released and shows the outcome on a row of status lamps. It drives a simple request/acknowledge bus as the only master. It issues five probes in a fixed order: a write and a read-back of the processor fault register, a read of memory word zero, a read of an address where nothing should answer, and a read of the console receiver status register. Every probe is bounded by a cycle-count timeout, so a missing slave cannot hang the sequence. Some probes pass only when the access times out.

Three lamps, one for each subsystem under test (core, memory, console), are lit from reset. Each lamp goes dark once every probe in its group has given the expected result. At the first unexpected result the sequence stops. The lamp for that group stays lit, and so do the lamps of all later groups, which points to the most likely faulty part. A fourth lamp follows a debug-mode input and is unrelated to the test. When the sequence ends, a one-cycle `done` pulse is issued and `pass` is set high. `pass` stays high only if every probe succeeded.

Top module: `selftest_led_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `led_core`, `led_mem` and `led_cons` are 1 and `led_dbg`, `done`, `pass` and `bus_req` are 0.
- R2: `led_dbg` equals the value that `dbg_mode` had at the previous clock edge, whatever state the test sequence is in.
- R3: Probes are issued one at a time in this order: write to 22'o17777766 (bus_we=1, bus_wdata=CER_WDATA), read of 22'o17777766, read of 22'o0, read of 22'o17777700, read of 22'o17777560.
- R4: Once `bus_req` rises, it stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until the edge at which `bus_ack` is sampled high, or until the timeout. `bus_req` is low in the cycle after that edge.
- R5: An access times out when `bus_ack` has not been sampled high on any of the TIMEOUT_CYC (default 64) clock edges at which `bus_req` was high. An acknowledge on the last of those edges still counts as a completed access.
- R6: `led_core` goes dark only when both accesses to the fault register complete without timeout. A timeout on either access is a core failure.
- R7: `led_mem` goes dark only when the read of address 0 completes and the read of 22'o17777700 times out.
- R8: `led_cons` goes dark only when the read of 22'o17777560 completes.
- R9: After the first failing probe, no further bus access is made. The failing group's lamp and every later group's lamp (order core, memory, console) stay lit until reset.
- R10: `done` is high for exactly one cycle per sequence. `pass` rises together with `done` only if every probe passed, stays high until reset, and is otherwise 0.
- R11: The read-back of the fault register also fails the core group when `(rdata ^ CER_WDATA) & RDBK_MASK` is nonzero (defaults CER_WDATA=16'h0000, RDBK_MASK=16'hFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; release starts the test |
| dbg_mode | input | 1 | High while the processor is in debug mode |
| bus_req | output | 1 | Access request, held until acknowledge or timeout |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 22 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Slave acknowledge, sampled while bus_req is high |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| led_dbg | output | 1 | Debug-mode lamp |
| led_core | output | 1 | Core lamp, lit until fault-register probes pass |
| led_cons | output | 1 | Console lamp, lit until the console probe passes |
| led_mem | output | 1 | Memory lamp, lit until both memory probes pass |
| done | output | 1 | One-cycle pulse when the sequence ends |
| pass | output | 1 | High after done when every probe passed |

## Verification
The bench places the acknowledge on the 64th request cycle and then on the 65th. A counter that is off by one either accepts the late answer or throws away the answer that was in time. It makes the probe that must time out get an answer, which catches a design that treats every completed access as a pass. It also gives a wrong read-back value, which catches a design that never compares the data. For each failure position it checks the exact set of lit lamps and the number of accesses logged after `done`, so a sequence that keeps running past a failure, or clears lamps out of order, is caught. It also measures how many cycles the timed-out request stays high, and it moves `dbg_mode` in the middle of a run to show that the debug lamp is independent of the test.

// File: rtl/pst_pkg.sv
// Shared constants and types for the power-up self-test sequencer.
// Assumes a 22-bit physical address space and one bus master.
package pst_pkg;

    localparam int ADDR_W  = 22;
    localparam int N_IND   = 3;
    localparam int N_PROBE = 5;

    localparam logic [ADDR_W-1:0] ADR_FAULT_REG = 22'o17777766;
    localparam logic [ADDR_W-1:0] ADR_MEM_ZERO  = 22'o0;
    localparam logic [ADDR_W-1:0] ADR_NO_SLAVE  = 22'o17777700;
    localparam logic [ADDR_W-1:0] ADR_CONS_STAT = 22'o17777560;

    // Lamp groups; the numeric order is the order in which groups are tested.
    typedef enum logic [1:0] {
        IND_CORE = 2'd0,
        IND_MEM  = 2'd1,
        IND_CONS = 2'd2
    } ind_e;

    typedef enum logic [1:0] {
        SQ_LAUNCH = 2'd0,
        SQ_WAIT   = 2'd1,
        SQ_STOP   = 2'd2
    } sq_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;        // probe is a write
        logic              want_tmo;  // probe passes only on timeout
        logic              chk_rd;    // compare read data with the written pattern
        ind_e              ind;       // lamp group the probe belongs to
        logic              closes;    // last probe of its group
    } probe_t;

    // Describe probe number idx of the fixed test program.
    function automatic probe_t probe_at(input logic [2:0] idx);
        probe_t p;
        p = '{addr: ADR_FAULT_REG, wr: 1'b1, want_tmo: 1'b0, chk_rd: 1'b0,
              ind: IND_CORE, closes: 1'b0};
        case (idx)
            3'd1: begin
                p.wr     = 1'b0;
                p.chk_rd = 1'b1;
                p.closes = 1'b1;
            end
            3'd2: begin
                p.addr = ADR_MEM_ZERO;
                p.wr   = 1'b0;
                p.ind  = IND_MEM;
            end
            3'd3: begin
                p.addr     = ADR_NO_SLAVE;
                p.wr       = 1'b0;
                p.want_tmo = 1'b1;
                p.ind      = IND_MEM;
                p.closes   = 1'b1;
            end
            3'd4: begin
                p.addr   = ADR_CONS_STAT;
                p.wr     = 1'b0;
                p.ind    = IND_CONS;
                p.closes = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pst_bus_master.sv
// Single-access bus master with a timeout.
// A go pulse while idle starts one access. The request is held until
// acknowledge or until TIMEOUT_CYC request cycles have gone by without one.
// Assumes go is only asserted while no access is in flight.
module pst_bus_master
    import pst_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_wdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              fin,
    output logic              fin_tmo,
    output logic [DATA_W-1:0] fin_rdata
);

    localparam int               CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] wait_cnt;

    // Start, hold and end one access; report how it ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            wait_cnt  <= '0;
            fin       <= 1'b0;
            fin_tmo   <= 1'b0;
            fin_rdata <= '0;
        end else begin
            fin <= 1'b0;
            if (go && !bus_req) begin
                bus_req   <= 1'b1;
                bus_we    <= go_we;
                bus_addr  <= go_addr;
                bus_wdata <= go_wdata;
                wait_cnt  <= '0;
            end else if (bus_req) begin
                if (bus_ack) begin
                    bus_req   <= 1'b0;
                    fin       <= 1'b1;
                    fin_tmo   <= 1'b0;
                    fin_rdata <= bus_rdata;
                end else if (wait_cnt == LIMIT) begin
                    bus_req <= 1'b0;
                    fin     <= 1'b1;
                    fin_tmo <= 1'b1;
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end
        end
    end

    AST_HOLD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))) // R4
        else $error("access fields changed while request held");

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> !bus_req) // R4
        else $error("request still high after acknowledge");

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !bus_req) // R4
        else $error("new access requested while one is in flight");

    AST_TMO_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && fin_tmo) |-> !$past(bus_ack)) // R5
        else $error("timeout reported although acknowledge was sampled");

endmodule

// File: rtl/pst_sequencer.sv
// Test program sequencer: steps through the probes, judges each result
// against what the probe expects, clears lamps, and ends with done/pass.
// Assumes one result pulse (fin) per launched probe from the bus master.
module pst_sequencer
    import pst_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter logic [DATA_W-1:0] CER_WDATA = '0,
    parameter logic [DATA_W-1:0] RDBK_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              go,
    output logic              go_we,
    output logic [ADDR_W-1:0] go_addr,
    output logic [DATA_W-1:0] go_wdata,
    input  logic              fin,
    input  logic              fin_tmo,
    input  logic [DATA_W-1:0] fin_rdata,
    output logic              clr,
    output ind_e              clr_ind,
    output logic              done,
    output logic              pass
);

    localparam logic [2:0] LAST_STEP = 3'(N_PROBE - 1);

    sq_e        state;
    logic [2:0] step;
    probe_t     cur;
    logic       rd_ok;
    logic       verdict;

    // Decode the current probe and judge the returned result.
    always_comb begin
        cur      = probe_at(step);
        go       = (state == SQ_LAUNCH);
        go_we    = cur.wr;
        go_addr  = cur.addr;
        go_wdata = CER_WDATA;
        rd_ok    = !cur.chk_rd || (((fin_rdata ^ CER_WDATA) & RDBK_MASK) == '0);
        verdict  = (fin_tmo == cur.want_tmo) && rd_ok;
    end

    // Step through the program, stop at the first wrong result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_LAUNCH;
            step    <= '0;
            clr     <= 1'b0;
            clr_ind <= IND_CORE;
            done    <= 1'b0;
            pass    <= 1'b0;
        end else begin
            done <= 1'b0;
            clr  <= 1'b0;
            case (state)
                SQ_LAUNCH: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (fin) begin
                        if (!verdict) begin
                            done  <= 1'b1;
                            state <= SQ_STOP;
                        end else begin
                            if (cur.closes) begin
                                clr     <= 1'b1;
                                clr_ind <= cur.ind;
                            end
                            if (step == LAST_STEP) begin
                                done  <= 1'b1;
                                pass  <= 1'b1;
                                state <= SQ_STOP;
                            end else begin
                                step  <= step + 1'b1;
                                state <= SQ_LAUNCH;
                            end
                        end
                    end
                end
                default: state <= SQ_STOP;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R10
        else $error("done held longer than one cycle");

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_STOP) |-> !go) // R9
        else $error("probe launched after the sequence ended");

    AST_DONE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fin)) // R10
        else $error("done without a preceding bus result");

endmodule

// File: rtl/pst_led_bank.sv
// Lamp register: the group lamps are lit at reset and each is cleared by a
// pulse naming its group. The debug lamp is a registered copy of the
// debug-mode input. Assumes at most one clear per cycle.
module pst_led_bank
    import pst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  ind_e             clr_ind,
    input  logic             dbg_in,
    output logic [N_IND-1:0] leds,
    output logic             led_dbg
);

    // One lamp per group, dark once its group is cleared.
    for (genvar g = 0; g < N_IND; g++) begin : g_lamp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                leds[g] <= 1'b1;
            end else if (clr && (clr_ind == ind_e'(g))) begin
                leds[g] <= 1'b0;
            end
        end

        AST_LAMP_NO_RELIGHT: assert property (@(posedge clk) disable iff (!rst_n)
            !leds[g] |=> !leds[g]) // R9
            else $error("group lamp lit again without reset");
    end

    // Debug lamp follows the mode input one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_dbg <= 1'b0;
        end else begin
            led_dbg <= dbg_in;
        end
    end

    AST_DBG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (led_dbg == $past(dbg_in))) // R2
        else $error("debug lamp does not follow debug input");

endmodule

// File: rtl/selftest_led_seq.sv
// Top of the power-up self-test: bus master, test sequencer and lamp bank.
// The test starts by itself when reset is released and runs once per reset.
// Assumes this block is the only master on the probe bus.
module selftest_led_seq
    import pst_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                TIMEOUT_CYC = 64,
    parameter logic [DATA_W-1:0] CER_WDATA   = '0,
    parameter logic [DATA_W-1:0] RDBK_MASK   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_mode,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              led_dbg,
    output logic              led_core,
    output logic              led_cons,
    output logic              led_mem,
    output logic              done,
    output logic              pass
);

    logic              go;
    logic              go_we;
    logic [ADDR_W-1:0] go_addr;
    logic [DATA_W-1:0] go_wdata;
    logic              fin;
    logic              fin_tmo;
    logic [DATA_W-1:0] fin_rdata;
    logic              clr;
    ind_e              clr_ind;
    logic [N_IND-1:0]  leds;

    pst_bus_master #(
        .DATA_W      (DATA_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_we     (go_we),
        .go_addr   (go_addr),
        .go_wdata  (go_wdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .fin       (fin),
        .fin_tmo   (fin_tmo),
        .fin_rdata (fin_rdata)
    );

    pst_sequencer #(
        .DATA_W    (DATA_W),
        .CER_WDATA (CER_WDATA),
        .RDBK_MASK (RDBK_MASK)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_we     (go_we),
        .go_addr   (go_addr),
        .go_wdata  (go_wdata),
        .fin       (fin),
        .fin_tmo   (fin_tmo),
        .fin_rdata (fin_rdata),
        .clr       (clr),
        .clr_ind   (clr_ind),
        .done      (done),
        .pass      (pass)
    );

    pst_led_bank u_leds (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .clr_ind (clr_ind),
        .dbg_in  (dbg_mode),
        .leds    (leds),
        .led_dbg (led_dbg)
    );

    // Map the group lamps onto named outputs.
    always_comb begin
        led_core = leds[IND_CORE];
        led_mem  = leds[IND_MEM];
        led_cons = leds[IND_CONS];
    end

    AST_PASS_ALL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pass) |-> (leds == '0)) // R10
        else $error("pass reported while a group lamp is lit");

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req) // R9
        else $error("bus active when the sequence ended");

endmodule

// File: tb/selftest_led_seq_tb.sv
// Directed bench: one task per scenario, slave model with a per-address answer map.
module selftest_led_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        bus_req, bus_we;
    logic [21:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        led_dbg, led_core, led_cons, led_mem, done, pass;

    int checks = 0;
    int errors = 0;

    // slave configuration: bit0 fault reg, bit1 mem zero, bit2 no-slave addr, bit3 console
    logic [3:0]  answer = 4'b1011;
    int          lat = 3;
    bit          corrupt = 0;
    logic [15:0] fault_val = 16'hBEEF;

    // access log
    logic [21:0] log_addr [0:15];
    logic        log_we   [0:15];
    logic [15:0] log_wd   [0:15];
    int          log_cyc  [0:15];
    int          nlog = 0;
    int          ndone = 0;
    int          wcnt = 0;
    int          hold_err = 0;

    always #10 clk = ~clk;

    selftest_led_seq u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .led_dbg(led_dbg), .led_core(led_core), .led_cons(led_cons),
        .led_mem(led_mem), .done(done), .pass(pass)
    );

    function automatic bit answers(input logic [21:0] a);
        if (a == 22'o17777766) return answer[0];
        if (a == 22'o0)        return answer[1];
        if (a == 22'o17777700) return answer[2];
        if (a == 22'o17777560) return answer[3];
        return 1'b0;
    endfunction

    // Slave model and monitor, acting on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            nlog = 0; ndone = 0; wcnt = 0; hold_err = 0;
            bus_ack = 1'b0;
        end else begin
            if (done) ndone = ndone + 1;
            if (!bus_req) begin
                wcnt = 0;
                bus_ack = 1'b0;
            end else begin
                if (wcnt == 0) begin
                    if (nlog < 16) begin
                        log_addr[nlog] = bus_addr;
                        log_we[nlog]   = bus_we;
                        log_wd[nlog]   = bus_wdata;
                        log_cyc[nlog]  = 0;
                    end
                    nlog = nlog + 1;
                end else if (nlog <= 16) begin
                    if (bus_addr != log_addr[nlog-1] || bus_we != log_we[nlog-1]
                        || bus_wdata != log_wd[nlog-1]) hold_err = hold_err + 1;
                end
                wcnt = wcnt + 1;
                if (nlog <= 16) log_cyc[nlog-1] = wcnt;
                bus_ack = answers(bus_addr) && (wcnt == lat);
                if (bus_ack && bus_we && bus_addr == 22'o17777766) fault_val = bus_wdata;
                if (bus_ack && !bus_we) bus_rdata = corrupt ? (fault_val ^ 16'h0001) : fault_val;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reset with a given slave setup, then release and wait for done.
    task automatic run(input logic [3:0] ans, input int l, input bit cor);
        bit seen = 0;
        @(negedge clk);
        rst_n = 1'b0;
        answer = ans; lat = l; corrupt = cor; fault_val = 16'hBEEF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
        if (!seen) begin
            checks++; errors++;
            $display("FAIL R10 watchdog: done never seen actual=0 expected=1");
        end
    endtask

    task automatic chk_end(input string tag, input int n_acc, input bit c, input bit m,
                           input bit s, input bit p);
        int n0 = nlog;
        repeat (100) @(negedge clk);
        chk(nlog == n_acc && n0 == n_acc, {tag, " R9 access count"}, nlog, n_acc);
        chk(led_core == c, {tag, " R6 led_core"}, led_core, c);
        chk(led_mem == m,  {tag, " R7 led_mem"}, led_mem, m);
        chk(led_cons == s, {tag, " R8 led_cons"}, led_cons, s);
        chk(pass == p, {tag, " R10 pass"}, pass, p);
        chk(ndone == 1, {tag, " R10 done pulses"}, ndone, 1);
        chk(hold_err == 0, {tag, " R4 fields held"}, hold_err, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; dbg_mode = 1'b1;
        repeat (3) @(negedge clk);
        chk({led_core, led_mem, led_cons} == 3'b111, "R1 lamps lit in reset",
            {led_core, led_mem, led_cons}, 3'b111);
        chk(!led_dbg && !done && !pass && !bus_req, "R1 outputs low in reset",
            {led_dbg, done, pass, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({led_core, led_mem, led_cons} == 3'b111, "R1 lamps lit after release",
            {led_core, led_mem, led_cons}, 3'b111);
        dbg_mode = 1'b0;
    endtask

    task automatic t_all_pass();
        run(4'b1011, 3, 0);
        chk(pass == 1'b1, "R10 pass with done", pass, 1);
        chk_end("all_pass", 5, 0, 0, 0, 1);
        chk(log_addr[0] == 22'o17777766 && log_we[0] && log_wd[0] == 16'h0000,
            "R3 probe0 write fault reg", log_addr[0], 22'o17777766);
        chk(log_addr[1] == 22'o17777766 && !log_we[1], "R3 probe1 read fault reg", log_addr[1], 22'o17777766);
        chk(log_addr[2] == 22'o0 && !log_we[2], "R3 probe2 read mem 0", log_addr[2], 0);
        chk(log_addr[3] == 22'o17777700 && !log_we[3], "R3 probe3 read no-slave", log_addr[3], 22'o17777700);
        chk(log_addr[4] == 22'o17777560 && !log_we[4], "R3 probe4 read console", log_addr[4], 22'o17777560);
        chk(log_cyc[3] == 64, "R5 timeout request length", log_cyc[3], 64);
        chk(log_cyc[0] == 3, "R4 request ends after ack", log_cyc[0], 3);
    endtask

    task automatic t_fault_dead();
        run(4'b1010, 3, 0);
        chk_end("fault_dead", 1, 1, 1, 1, 0);
    endtask

    task automatic t_readback_bad();
        run(4'b1011, 2, 1);
        chk_end("readback_bad R11", 2, 1, 1, 1, 0);
    endtask

    task automatic t_mem_dead();
        run(4'b1001, 2, 0);
        chk_end("mem_dead", 3, 0, 1, 1, 0);
    endtask

    task automatic t_noslave_answers();
        run(4'b1111, 2, 0);
        chk_end("noslave_answers", 4, 0, 1, 1, 0);
    endtask

    task automatic t_cons_dead();
        run(4'b0011, 1, 0);
        chk_end("cons_dead", 5, 0, 0, 1, 0);
    endtask

    task automatic t_latency_edges();
        run(4'b1011, 64, 0);
        chk_end("R5 ack on last cycle", 5, 0, 0, 0, 1);
        run(4'b1011, 65, 0);
        chk_end("R5 ack one cycle late", 1, 1, 1, 1, 0);
        chk(log_cyc[0] == 64, "R5 late ack request length", log_cyc[0], 64);
    endtask

    task automatic t_debug_lamp();
        @(negedge clk);
        rst_n = 1'b0; answer = 4'b1011; lat = 20; corrupt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        dbg_mode = 1'b1;
        @(negedge clk);
        chk(led_dbg == 1'b1, "R2 debug lamp on", led_dbg, 1);
        chk(led_core == 1'b1 && !done, "R2 sequence unaffected", led_core, 1);
        dbg_mode = 1'b0;
        @(negedge clk);
        chk(led_dbg == 1'b0, "R2 debug lamp off", led_dbg, 0);
        dbg_mode = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        repeat (2) @(negedge clk);
        chk(led_dbg == 1'b1 && pass == 1'b1, "R2 debug lamp after done", led_dbg, 1);
        dbg_mode = 1'b0;
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_all_pass();
        t_fault_dead();
        t_readback_bad();
        t_mem_dead();
        t_noslave_answers();
        t_cons_dead();
        t_latency_edges();
        t_debug_lamp();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule